// File: doc/BRIEF.md
# Multiple Inner Product Accumulator

This block works through one loaded section of a column-blocked sparse matrix in a single operation. A section holds up to `SECT` non-zero values. Each value comes with a column position inside the current vertical block and an end-of-row marker. The block multiplies every value by the dense multiplicand element that its column position selects. It sums the products of each row run, where the end-of-row markers mark where one run stops and the next begins. It adds each run total to the matching accumulator entry and returns the updated entries in their original order. Entries for empty rows are removed before a section reaches this block, so every lane carries a real non-zero value.

Operation is sequential: one element per clock. The multiplicand slice stays the same for all sections of a vertical block, while values, positions and markers change from one section to the next. Control uses plain pins: a `start` pulse while idle captures every operand. `busy` stays high for the whole run, and `done` pulses once when the result is ready. Operands and results are flat register-array ports, so no streaming handshake and no back-pressure are involved. `start` is refused while `busy` is high. All arithmetic is signed two's complement at `DW` bits, and it wraps on overflow.

Top module: `mipa_top`

## Requirements
- R1: The product for lane i is `vals` lane i times `bvec` lane k, where k is the column position held in `cpos[i*CPW +: CPW]`. Value and vector lanes sit at `[i*DW +: DW]`.
- R2: When `eor[i]` is 1, the running sum ends after lane i, and lane i+1 begins a new sum from zero.
- R3: The j-th completed sum (counting from 0) is added to `cin` lane j. Every lane of `cout` gives the updated entry at the same lane position.
- R4: If the last active lane carries no end-of-row marker, its open sum is still added to the next result slot.
- R5: Lanes at or above `elem_count` do not take part. Result slots beyond the number of sums come out equal to `cin`. An `elem_count` above `SECT` is treated as `SECT`.
- R6: Products, sums and accumulator updates are signed `DW`-bit values that wrap on overflow.
- R7: `done` is a one-cycle pulse. It rises after the n+1-th rising edge that follows the edge that accepted `start`, where n is the clamped count. With n = 0, `done` rises after one edge and `cout` equals `cin`.
- R8: `busy` is high from the edge that accepts `start` until the edge that raises `done`. During that time, `start` and any change on the operand inputs have no effect on the result.
- R9: While idle, `cout` holds its last result until the next accepted `start`, whatever happens on `cin`.
- R10: After reset, `busy` and `done` are 0 and `cout` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; taken only while idle |
| elem_count | input | CNTW | Number of active lanes, clamped to SECT |
| vals | input | SECT*DW | Non-zero matrix values, lane i at [i*DW +: DW] |
| cpos | input | SECT*CPW | Column position of each value inside the block |
| eor | input | SECT | End-of-row marker per lane |
| bvec | input | SECT*DW | Dense multiplicand slice of the vertical block |
| cin | input | SECT*DW | Result entries of the section's non-empty rows |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cout | output | SECT*DW | Updated result entries, held until the next start |

## Verification
A wrong column selection or a stale sum register shows up as a wrong value in one `cout` lane as soon as `done` rises. The next row's slot also comes out wrong, because the sum carries over. A slip in the group pointer damages every later slot, and it also breaks the pass-through of unused slots. Each mismatch therefore points to the first faulty group. A wrong element counter shows up as a `done` latency that differs from n+1 on the very first operation, so it can be seen even when the data happens to match.

// File: rtl/mipa_pkg.sv
package mipa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mipa_state_e;
endpackage

// File: rtl/mipa_ctrl.sv
module mipa_ctrl #(
  parameter int SECT = 8,
  parameter int IDXW = $clog2(SECT),
  parameter int CNTW = $clog2(SECT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CNTW-1:0] elem_count,
  output logic            load,
  output logic            step,
  output logic            last,
  output logic [IDXW-1:0] lane,
  output logic            busy,
  output logic            done
);
  import mipa_pkg::*;

  localparam logic [CNTW-1:0] SECT_C = CNTW'(SECT);

  mipa_state_e     state_q;
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] cnt_clamped;

  assign cnt_clamped = (elem_count > SECT_C) ? SECT_C : elem_count;
  assign load = (state_q == ST_IDLE) && start;
  assign step = (state_q == ST_RUN);
  assign last = (CNTW'(lane) == cnt_q - CNTW'(1));
  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lane    <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state_q == ST_FIN);
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            cnt_q   <= cnt_clamped;
            lane    <= '0;
            state_q <= (cnt_clamped == '0) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          lane <= lane + IDXW'(1);
          if (last) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mipa_operands.sv
module mipa_operands #(
  parameter int SECT = 8,
  parameter int DW   = 16,
  parameter int IDXW = $clog2(SECT)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [SECT-1:0][DW-1:0]    vals_in,
  input  logic [SECT-1:0][IDXW-1:0]  cpos_in,
  input  logic [SECT-1:0]            eor_in,
  input  logic [SECT-1:0][DW-1:0]    bvec_in,
  output logic [SECT-1:0][DW-1:0]    vals_q,
  output logic [SECT-1:0][IDXW-1:0]  cpos_q,
  output logic [SECT-1:0]            eor_q,
  output logic [SECT-1:0][DW-1:0]    bvec_q
);
  for (genvar g = 0; g < SECT; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vals_q[g] <= '0;
        cpos_q[g] <= '0;
        eor_q[g]  <= 1'b0;
        bvec_q[g] <= '0;
      end else if (load) begin
        vals_q[g] <= vals_in[g];
        cpos_q[g] <= cpos_in[g];
        eor_q[g]  <= eor_in[g];
        bvec_q[g] <= bvec_in[g];
      end
    end
  end
endmodule

// File: rtl/mipa_lane_mul.sv
module mipa_lane_mul #(
  parameter int SECT = 8,
  parameter int DW   = 16,
  parameter int IDXW = $clog2(SECT)
) (
  input  logic [SECT-1:0][DW-1:0]    vals_q,
  input  logic [SECT-1:0][IDXW-1:0]  cpos_q,
  input  logic [SECT-1:0]            eor_q,
  input  logic [SECT-1:0][DW-1:0]    bvec_q,
  input  logic [IDXW-1:0]            lane,
  output logic signed [DW-1:0]       prod,
  output logic                       row_end
);
  logic signed [DW-1:0]   a_sel;
  logic signed [DW-1:0]   b_sel;
  logic signed [2*DW-1:0] full;

  always_comb begin
    a_sel   = vals_q[lane];
    b_sel   = bvec_q[cpos_q[lane]];
    row_end = eor_q[lane];
    full    = a_sel * b_sel;
    prod    = full[DW-1:0];
  end
endmodule

// File: rtl/mipa_group_acc.sv
module mipa_group_acc #(
  parameter int SECT = 8,
  parameter int DW   = 16,
  parameter int IDXW = $clog2(SECT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  input  logic                    close,
  input  logic signed [DW-1:0]    prod,
  input  logic [SECT-1:0][DW-1:0] cin,
  output logic [SECT-1:0][DW-1:0] res_q
);
  logic signed [DW-1:0] acc_q;
  logic signed [DW-1:0] run_sum;
  logic [IDXW-1:0]      grp_q;

  assign run_sum = acc_q + prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      grp_q <= '0;
      res_q <= '0;
    end else if (load) begin
      acc_q <= '0;
      grp_q <= '0;
      res_q <= cin;
    end else if (step) begin
      if (close) begin
        res_q[grp_q] <= $signed(res_q[grp_q]) + run_sum;
        grp_q        <= grp_q + IDXW'(1);
        acc_q        <= '0;
      end else begin
        acc_q <= run_sum;
      end
    end
  end
endmodule

// File: rtl/mipa_top.sv
module mipa_top #(
  parameter int SECT = 8,
  parameter int DW   = 16,
  parameter int CPW  = $clog2(SECT),
  parameter int CNTW = $clog2(SECT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CNTW-1:0]      elem_count,
  input  logic [SECT*DW-1:0]   vals,
  input  logic [SECT*CPW-1:0]  cpos,
  input  logic [SECT-1:0]      eor,
  input  logic [SECT*DW-1:0]   bvec,
  input  logic [SECT*DW-1:0]   cin,
  output logic                 busy,
  output logic                 done,
  output logic [SECT*DW-1:0]   cout
);
  logic                       load, step, last, row_end;
  logic [CPW-1:0]             lane;
  logic signed [DW-1:0]       prod;
  logic [SECT-1:0][DW-1:0]    vals_q, bvec_q, res_q;
  logic [SECT-1:0][CPW-1:0]   cpos_q;
  logic [SECT-1:0]            eor_q;

  mipa_ctrl #(.SECT(SECT), .IDXW(CPW), .CNTW(CNTW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .elem_count(elem_count),
    .load(load), .step(step), .last(last), .lane(lane),
    .busy(busy), .done(done)
  );

  mipa_operands #(.SECT(SECT), .DW(DW), .IDXW(CPW)) u_ops (
    .clk(clk), .rst_n(rst_n), .load(load),
    .vals_in(vals), .cpos_in(cpos), .eor_in(eor), .bvec_in(bvec),
    .vals_q(vals_q), .cpos_q(cpos_q), .eor_q(eor_q), .bvec_q(bvec_q)
  );

  mipa_lane_mul #(.SECT(SECT), .DW(DW), .IDXW(CPW)) u_mul (
    .vals_q(vals_q), .cpos_q(cpos_q), .eor_q(eor_q), .bvec_q(bvec_q),
    .lane(lane), .prod(prod), .row_end(row_end)
  );

  mipa_group_acc #(.SECT(SECT), .DW(DW), .IDXW(CPW)) u_acc (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .close(row_end | last), .prod(prod), .cin(cin), .res_q(res_q)
  );

  assign cout = res_q;
endmodule

// File: rtl/mipa_checker.sv
module mipa_checker #(
  parameter int SECT = 8,
  parameter int DW   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [SECT*DW-1:0] cout
);
  localparam int RUNW = $clog2(SECT + 3) + 1;
  logic [RUNW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_len <= '0;
    else if (busy) run_len <= run_len + RUNW'(1);
    else           run_len <= '0;
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_run_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= RUNW'(SECT + 1));

  assert_accept_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(cout));
endmodule

bind mipa_top mipa_checker #(.SECT(SECT), .DW(DW)) u_mipa_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .cout(cout)
);

// File: tb/mipa_top_test.sv
module mipa_top_test;
  localparam int SECT = 8;
  localparam int DW   = 16;
  localparam int CPW  = $clog2(SECT);
  localparam int CNTW = $clog2(SECT + 1);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [CNTW-1:0]     elem_count = '0;
  logic [SECT*DW-1:0]  vals = '0, bvec = '0, cin = '0;
  logic [SECT*CPW-1:0] cpos = '0;
  logic [SECT-1:0]     eor = '0;
  logic                busy, done;
  logic [SECT*DW-1:0]  cout;

  int test_cnt = 0;
  int fail_cnt = 0;

  logic signed [DW-1:0] tv_val [SECT];
  logic signed [DW-1:0] tv_b   [SECT];
  logic signed [DW-1:0] tv_c   [SECT];
  logic [CPW-1:0]       tv_cp  [SECT];
  logic                 tv_eor [SECT];
  logic signed [DW-1:0] exp_c  [SECT];

  always #4 clk = ~clk;

  mipa_top #(.SECT(SECT), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .elem_count(elem_count),
    .vals(vals), .cpos(cpos), .eor(eor), .bvec(bvec), .cin(cin),
    .busy(busy), .done(done), .cout(cout)
  );

  initial begin
    repeat (150000) @(posedge clk);
    fail_cnt++;
    test_cnt++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", test_cnt, fail_cnt);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    test_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input int cnt);
    int n;
    logic signed [DW-1:0] acc;
    int g;
    n = (cnt > SECT) ? SECT : cnt;
    for (int i = 0; i < SECT; i++) exp_c[i] = tv_c[i];
    acc = '0;
    g = 0;
    for (int i = 0; i < n; i++) begin
      logic signed [DW-1:0] p;
      p   = tv_val[i] * tv_b[tv_cp[i]];
      acc = acc + p;
      if (tv_eor[i] || i == n - 1) begin
        exp_c[g] = exp_c[g] + acc;
        g++;
        acc = '0;
      end
    end
  endfunction

  task automatic drive_ops(input int cnt);
    elem_count = CNTW'(cnt);
    for (int i = 0; i < SECT; i++) begin
      vals[i*DW +: DW]   = tv_val[i];
      bvec[i*DW +: DW]   = tv_b[i];
      cin[i*DW +: DW]    = tv_c[i];
      cpos[i*CPW +: CPW] = tv_cp[i];
      eor[i]             = tv_eor[i];
    end
  endtask

  task automatic compare_out(input string req);
    for (int i = 0; i < SECT; i++)
      check($signed(cout[i*DW +: DW]) == exp_c[i], req, $sformatf("slot %0d", i),
            longint'($signed(cout[i*DW +: DW])), longint'(exp_c[i]));
  endtask

  // runs one operation; disturb=1 pokes start and operands while busy (R8)
  task automatic run_op(input int cnt, input string req, input bit disturb);
    int lat;
    int n;
    n = (cnt > SECT) ? SECT : cnt;
    model(cnt);
    @(negedge clk);
    drive_ops(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8", "busy after start", longint'(busy), 1);
    if (disturb) begin
      start = 1'b1;
      vals = ~vals;
      bvec = bvec + 1;
      cin  = ~cin;
      eor  = ~eor;
      elem_count = ~elem_count;
    end
    lat = 0;
    while (!done && lat < 40) begin
      @(posedge clk);
      #1;
      lat++;
    end
    start = 1'b0;
    check(lat == n + 1, "R7", "done latency", longint'(lat), longint'(n + 1));
    compare_out(req);
    @(posedge clk);
    #1;
    check(done == 1'b0 && busy == 1'b0, "R7", "done one cycle",
          longint'({busy, done}), 0);
  endtask

  task automatic rand_ops(input int eor_pct);
    for (int i = 0; i < SECT; i++) begin
      tv_val[i] = DW'($urandom);
      tv_b[i]   = DW'($urandom_range(0, 255)) - DW'(128);
      tv_c[i]   = DW'($urandom);
      tv_cp[i]  = CPW'($urandom_range(0, SECT - 1));
      tv_eor[i] = ($urandom_range(0, 99) < eor_pct);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check(busy == 1'b0 && done == 1'b0, "R10", "control after reset",
          longint'({busy, done}), 0);
    check(cout == '0, "R10", "cout after reset", longint'(cout[DW-1:0]), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: column selection, one element per row
    for (int i = 0; i < SECT; i++) begin
      tv_val[i] = DW'(i + 1);
      tv_b[i]   = DW'(10 * (i + 1));
      tv_c[i]   = DW'(1000);
      tv_cp[i]  = CPW'(SECT - 1 - i);
      tv_eor[i] = 1'b1;
    end
    run_op(SECT, "R1", 1'b0);

    // R2: one long row, then R3 ordering of two groups
    for (int i = 0; i < SECT; i++) tv_eor[i] = 1'b0;
    tv_eor[2] = 1'b1;
    tv_eor[SECT-1] = 1'b1;
    run_op(SECT, "R2", 1'b0);

    // R4: final group without closing marker
    for (int i = 0; i < SECT; i++) tv_eor[i] = 1'b0;
    tv_eor[0] = 1'b1;
    run_op(5, "R4", 1'b0);

    // R5: few lanes, passthrough of the rest, clamp of large count
    run_op(2, "R5", 1'b0);
    run_op(0, "R5", 1'b0);
    rand_ops(30);
    run_op(15, "R5", 1'b0);

    // R6: wrap-around
    for (int i = 0; i < SECT; i++) begin
      tv_val[i] = 16'sh7fff;
      tv_b[i]   = 16'sh7fff;
      tv_c[i]   = 16'sh7ff0;
      tv_cp[i]  = CPW'(i);
      tv_eor[i] = (i % 3 == 2);
    end
    run_op(SECT, "R6", 1'b0);

    // R8: inputs disturbed while busy
    rand_ops(40);
    run_op(6, "R8", 1'b1);

    // R9: idle hold while cin changes
    begin
      logic [SECT*DW-1:0] held;
      held = cout;
      @(negedge clk);
      cin = ~cin;
      repeat (3) @(negedge clk);
      check(cout == held, "R9", "cout held while idle",
            longint'(cout[DW-1:0]), longint'(held[DW-1:0]));
    end

    // random mix, R3
    for (int t = 0; t < 300; t++) begin
      rand_ops($urandom_range(0, 100));
      run_op($urandom_range(0, SECT + 2), "R3", (t % 7) == 3);
    end

    $display("  [TB] %0d tests run, %0d failed", test_cnt, fail_cnt);
    $finish;
  end
endmodule